// File: doc/BRIEF.md
# Programmable Serial Shift Slice

This block is one lane of a general-purpose serial engine. A 32-bit shift register moves one bit per shift clock toward its least significant end. Bit 0 drives the serial data pin. The top bit is filled from the serial input pin, or in loopback mode from the bit just leaving. Several lanes built from this slice can be combined to produce or capture audio-style streams on generic I/O.

The shift clock has two sources. The first is an internal down-counter that reloads from a divide value. The second is the falling edge of an external pin, taken through a two-stage synchronizer. A separate frame counter sets the effective word length. When it runs out, the working register and a holding register trade contents on the same shift clock, and a one-cycle frame pulse is raised. Software preloads the holding register with the next word through a simple write strobe. After the trade it finds the captured word there.

The slice also puts out a clock that changes level on every shift, with selectable polarity, and an output enable that follows a configuration bit. While the slice is disabled, all counters sit at their start values, so lanes enabled together stay in phase.

Top module: `serial_shift_slice`

## Requirements
- R1: In internal clock mode (cfg_ext_clk=0), with count start value 0, a shift occurs on the first enabled cycle and then every cfg_preset+1 cycles. A value of 0 shifts on every cycle.
- R2: While enable is 0, no shift occurs. The divider holds cfg_count_init, the frame counter holds its reload value, the output clock level returns to its idle state and exchange stays 0.
- R3: A start value cfg_count_init of N delays the first internal shift after enable by N cycles, which moves the output clock phase relative to the data.
- R4: The frame counter starts at its reload value (cfg_pos_preset) and counts shifts down. The shift taken when it is 0 is an exchange shift, so exchanges fall every cfg_pos_preset+1 shifts. exchange is high for exactly the one cycle after each exchange shift.
- R5: On an exchange shift, the working register takes the holding register's old value, and the holding register takes the working register's value after that shift.
- R6: With cfg_self_loop=1, the incoming top bit is the outgoing bit 0, and the frame reload value is forced to 31 whatever cfg_pos_preset holds.
- R7: Each shift moves the working register right by one. dout is bit 0, and the new bit 31 is din as sampled on that shift cycle.
- R8: With cfg_ext_clk=1, a high-to-low change of ext_pin causes exactly one shift, on the third rising clock edge at which the pin is sampled low. The internal divider neither shifts nor counts in this mode.
- R9: The output clock level changes on every shift. clk_out equals that level XOR cfg_inv_clk, and the level is 0 after reset and while disabled.
- R10: oe equals cfg_oe delayed by one clock.
- R11: A synchronous reset (rst=1) clears both counters, both registers, the clock level, exchange and oe.
- R12: shadow_wr=1 loads shadow_wdata into the holding register on the next edge, unless that edge is an exchange shift, in which case the exchange wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the slice; 0 holds counters at start values |
| cfg_ext_clk | input | 1 | Shift clock source: 0 internal divider, 1 external pin falling edge |
| cfg_inv_clk | input | 1 | Inverts clk_out |
| cfg_self_loop | input | 1 | Loopback: bit 0 re-enters at bit 31, length forced to 32 |
| cfg_oe | input | 1 | Requested output enable level |
| cfg_preset | input | PRE_W | Divider reload value (divide by value+1) |
| cfg_count_init | input | PRE_W | Divider start value while disabled |
| cfg_pos_preset | input | POS_W | Frame counter reload value (word length minus 1) |
| ext_pin | input | 1 | External shift clock pin, asynchronous |
| din | input | 1 | Serial input bit |
| shadow_wr | input | 1 | Load strobe for the holding register |
| shadow_wdata | input | WIDTH | Word for the holding register |
| dout | output | 1 | Serial output bit (working register bit 0) |
| oe | output | 1 | Output enable |
| clk_out | output | 1 | Divided shift clock output |
| exchange | output | 1 | One-cycle pulse after each register exchange |

## Verification
The divider reload property assumes that cfg_preset does not change between the cycle where the counter is at zero and the reload edge. The stimulus changes configuration only while the slice is disabled or in reset, which keeps to this. The properties also assume that cfg_count_init is no larger than cfg_preset in internal mode, and the stimulus uses start values of 0 and 2 against larger divide values. ext_pin is changed only at falling clock edges and held low or high for several cycles, so each edge the synchronizer sees is clean.

// File: rtl/slice_pkg.sv
package slice_pkg;
    localparam int DEF_WIDTH = 32;
    localparam int DEF_PRE_W = 12;

    typedef enum logic {
        CLK_SRC_DIV = 1'b0,
        CLK_SRC_PIN = 1'b1
    } clk_src_e;
endpackage

// File: rtl/slice_edge_sync.sv
module slice_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fall_o = st_q.s3 & ~st_q.s2;
endmodule

// File: rtl/slice_clkdiv.sv
module slice_clkdiv
    import slice_pkg::*;
#(
    parameter int PRE_W = DEF_PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  clk_src_e         src_i,
    input  logic [PRE_W-1:0] preset_i,
    input  logic [PRE_W-1:0] count_init_i,
    input  logic             pin_fall_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } div_t;

    div_t st_d, st_q;
    logic at_zero;

    assign at_zero = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d.cnt = count_init_i;
        end else if (src_i == CLK_SRC_DIV) begin
            st_d.cnt = at_zero ? preset_i : st_q.cnt - 1'b1;
        end
        tick_o = enable_i && ((src_i == CLK_SRC_PIN) ? pin_fall_i : at_zero);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R1: a zero count in internal mode reloads the divide value on the next edge
    a_r1_reload: assert property (@(posedge clk) disable iff (rst)
        (enable_i && src_i == CLK_SRC_DIV && at_zero) |=> (st_q.cnt == $past(preset_i)));

    // R2: a disabled divider produces no shift
    a_r2_no_tick_idle: assert property (@(posedge clk) disable iff (rst)
        !enable_i |-> !tick_o);
endmodule

// File: rtl/slice_poscnt.sv
module slice_poscnt #(
    parameter int WIDTH = 32,
    parameter int POS_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic             self_loop_i,
    input  logic [POS_W-1:0] pos_preset_i,
    output logic             wrap_o,
    output logic             exchange_o
);
    localparam logic [POS_W-1:0] FULL_LEN = POS_W'(WIDTH - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             exch;
    } pos_t;

    pos_t st_d, st_q;
    logic [POS_W-1:0] reload;

    assign reload = self_loop_i ? FULL_LEN : pos_preset_i;
    assign wrap_o = tick_i && (st_q.pos == '0);

    always_comb begin
        st_d      = st_q;
        st_d.exch = 1'b0;
        if (!enable_i) begin
            st_d.pos = reload;
        end else if (tick_i) begin
            if (st_q.pos == '0) begin
                st_d.pos  = reload;
                st_d.exch = 1'b1;
            end else begin
                st_d.pos = st_q.pos - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign exchange_o = st_q.exch;

    // R4: an exchange pulse only follows a shift taken at frame position zero
    a_r4_exch_origin: assert property (@(posedge clk) disable iff (rst)
        exchange_o |-> ($past(tick_i) && $past(st_q.pos) == '0));

    // R6: loopback always restarts a full-length frame
    a_r6_full_len: assert property (@(posedge clk) disable iff (rst)
        (tick_i && self_loop_i && st_q.pos == '0) |=> (st_q.pos == FULL_LEN));
endmodule

// File: rtl/slice_shifter.sv
module slice_shifter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             wrap_i,
    input  logic             self_loop_i,
    input  logic             din_i,
    input  logic             shadow_wr_i,
    input  logic [WIDTH-1:0] shadow_wdata_i,
    output logic             dout_o
);
    typedef struct packed {
        logic [WIDTH-1:0] work;
        logic [WIDTH-1:0] hold;
    } regs_t;

    regs_t st_d, st_q;
    logic             fill_bit;
    logic [WIDTH-1:0] shifted;

    assign fill_bit = self_loop_i ? st_q.work[0] : din_i;
    assign shifted  = {fill_bit, st_q.work[WIDTH-1:1]};

    always_comb begin
        st_d = st_q;
        if (shadow_wr_i) st_d.hold = shadow_wdata_i;
        if (tick_i) begin
            if (wrap_i) begin
                st_d.work = st_q.hold;
                st_d.hold = shifted;
            end else begin
                st_d.work = shifted;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout_o = st_q.work[0];

    // R7: a plain shift moves every bit one place toward bit 0
    a_r7_shift_right: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !wrap_i) |=> (st_q.work[WIDTH-2:0] == $past(st_q.work[WIDTH-1:1])));

    // R5: the exchange shift installs the old holding word
    a_r5_swap_in: assert property (@(posedge clk) disable iff (rst)
        (tick_i && wrap_i) |=> (st_q.work == $past(st_q.hold)));

    // R12: a write without an exchange lands in the holding register
    a_r12_hold_write: assert property (@(posedge clk) disable iff (rst)
        (shadow_wr_i && !(tick_i && wrap_i)) |=> (st_q.hold == $past(shadow_wdata_i)));
endmodule

// File: rtl/serial_shift_slice.sv
module serial_shift_slice
    import slice_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    parameter int PRE_W = DEF_PRE_W,
    parameter int POS_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             cfg_ext_clk,
    input  logic             cfg_inv_clk,
    input  logic             cfg_self_loop,
    input  logic             cfg_oe,
    input  logic [PRE_W-1:0] cfg_preset,
    input  logic [PRE_W-1:0] cfg_count_init,
    input  logic [POS_W-1:0] cfg_pos_preset,
    input  logic             ext_pin,
    input  logic             din,
    input  logic             shadow_wr,
    input  logic [WIDTH-1:0] shadow_wdata,
    output logic             dout,
    output logic             oe,
    output logic             clk_out,
    output logic             exchange
);
    typedef struct packed {
        logic level;
        logic oe;
    } top_t;

    top_t     st_d, st_q;
    clk_src_e src;
    logic     pin_fall;
    logic     tick;
    logic     wrap;

    assign src = clk_src_e'(cfg_ext_clk);

    slice_edge_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ext_pin),
        .fall_o (pin_fall)
    );

    slice_clkdiv #(.PRE_W(PRE_W)) u_div (
        .clk          (clk),
        .rst          (rst),
        .enable_i     (enable),
        .src_i        (src),
        .preset_i     (cfg_preset),
        .count_init_i (cfg_count_init),
        .pin_fall_i   (pin_fall),
        .tick_o       (tick)
    );

    slice_poscnt #(.WIDTH(WIDTH), .POS_W(POS_W)) u_pos (
        .clk          (clk),
        .rst          (rst),
        .enable_i     (enable),
        .tick_i       (tick),
        .self_loop_i  (cfg_self_loop),
        .pos_preset_i (cfg_pos_preset),
        .wrap_o       (wrap),
        .exchange_o   (exchange)
    );

    slice_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk            (clk),
        .rst            (rst),
        .tick_i         (tick),
        .wrap_i         (wrap),
        .self_loop_i    (cfg_self_loop),
        .din_i          (din),
        .shadow_wr_i    (shadow_wr),
        .shadow_wdata_i (shadow_wdata),
        .dout_o         (dout)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = cfg_oe;
        if (!enable)   st_d.level = 1'b0;
        else if (tick) st_d.level = ~st_q.level;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign clk_out = st_q.level ^ cfg_inv_clk;
    assign oe      = st_q.oe;

    // R9: the clock level only moves on a shift while running
    a_r9_level_hold: assert property (@(posedge clk) disable iff (rst)
        (enable && !tick) |=> $stable(st_q.level));

    // R2: a disabled slice raises no exchange pulse
    a_r2_no_exch_idle: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !exchange);
endmodule

// File: tb/sim_serial_shift_slice.sv
module sim_serial_shift_slice;
    localparam int W  = 32;
    localparam int PW = 12;
    localparam int QW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic          cfg_ext_clk = 1'b0;
    logic          cfg_inv_clk = 1'b0;
    logic          cfg_self_loop = 1'b0;
    logic          cfg_oe = 1'b0;
    logic [PW-1:0] cfg_preset = '0;
    logic [PW-1:0] cfg_count_init = '0;
    logic [QW-1:0] cfg_pos_preset = '0;
    logic          ext_pin = 1'b0;
    logic          din = 1'b0;
    logic          shadow_wr = 1'b0;
    logic [W-1:0]  shadow_wdata = '0;
    logic          dout, oe, clk_out, exchange;

    always #5 clk = ~clk;

    serial_shift_slice u0 (
        .clk(clk), .rst(rst), .enable(enable), .cfg_ext_clk(cfg_ext_clk),
        .cfg_inv_clk(cfg_inv_clk), .cfg_self_loop(cfg_self_loop), .cfg_oe(cfg_oe),
        .cfg_preset(cfg_preset), .cfg_count_init(cfg_count_init),
        .cfg_pos_preset(cfg_pos_preset), .ext_pin(ext_pin), .din(din),
        .shadow_wr(shadow_wr), .shadow_wdata(shadow_wdata),
        .dout(dout), .oe(oe), .clk_out(clk_out), .exchange(exchange)
    );

    // behavioural reference model
    int            m_cnt, m_pos;
    logic [W-1:0]  m_work, m_hold;
    bit            m_level, m_exch, m_oe;
    bit            pin_hist[$];

    int vectors = 0;
    int fails   = 0;
    string cur_req = "R11";
    int cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) begin
        bit tick, fill, fall;
        int reload;
        logic [W-1:0] nxt;
        fall = (pin_hist.size() == 3) && pin_hist[0] && !pin_hist[1];
        reload = cfg_self_loop ? 31 : int'(cfg_pos_preset);
        if (rst) begin
            m_cnt = 0; m_pos = 0; m_work = '0; m_hold = '0;
            m_level = 0; m_exch = 0; m_oe = 0;
            pin_hist = '{0, 0, 0};
        end else begin
            m_oe = cfg_oe;
            m_exch = 0;
            if (!enable) begin
                m_cnt = int'(cfg_count_init);
                m_pos = reload;
                m_level = 0;
                if (shadow_wr) m_hold = shadow_wdata;
            end else begin
                if (cfg_ext_clk) tick = fall;
                else begin
                    tick = (m_cnt == 0);
                    m_cnt = (m_cnt == 0) ? int'(cfg_preset) : m_cnt - 1;
                end
                if (shadow_wr && !(tick && m_pos == 0)) m_hold = shadow_wdata;
                if (tick) begin
                    fill = cfg_self_loop ? m_work[0] : din;
                    nxt = (m_work >> 1) | ({{(W-1){1'b0}}, fill} << (W-1));
                    m_level = !m_level;
                    if (m_pos == 0) begin
                        m_work = m_hold;
                        m_hold = nxt;
                        m_pos = reload;
                        m_exch = 1;
                    end else begin
                        m_work = nxt;
                        m_pos--;
                    end
                end
            end
            void'(pin_hist.pop_front());
            pin_hist.push_back(ext_pin);
        end
    end

    task automatic compare();
        logic [3:0] act, exp;
        act = {dout, oe, clk_out, exchange};
        exp = {m_work[0], m_oe, m_level ^ cfg_inv_clk, m_exch};
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t {dout,oe,clk_out,exchange} actual=%b expected=%b",
                     cur_req, $time, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            din = lfsr[0];
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d cycles expected<=20000", cycles);
            finish_run();
        end
    end

    int exch_seen;

    initial begin
        // R11: reset state
        cur_req = "R11";
        step(4);
        rst = 1'b0;
        // R12 and R2: holding-register load while disabled, nothing moves
        cur_req = "R12";
        shadow_wdata = 32'hA5A5_0F0F; shadow_wr = 1'b1;
        step(1);
        shadow_wr = 1'b0;
        cur_req = "R2";
        step(6);
        // R1, R4, R5, R7: internal divide by 4, 8-bit frames
        cur_req = "R1";
        cfg_preset = 12'd3; cfg_pos_preset = 5'd7; enable = 1'b1;
        step(40);
        cur_req = "R4";
        exch_seen = 0;
        for (int i = 0; i < 80; i++) begin
            step(1);
            if (exchange) exch_seen++;
        end
        vectors++;
        // R4: 80 cycles at 4 cycles per shift = 20 shifts, 8 per frame
        if (exch_seen < 2 || exch_seen > 3) begin
            fails++;
            $display("FAIL R4 exchange count actual=%0d expected=2..3", exch_seen);
        end
        cur_req = "R5";
        shadow_wdata = 32'h1234_5678; shadow_wr = 1'b1;
        step(1);
        shadow_wr = 1'b0;
        step(80);
        // R7: undivided clock, full 32-bit frames
        cur_req = "R7";
        enable = 1'b0; step(2);
        cfg_preset = 12'd0; cfg_pos_preset = 5'd31; enable = 1'b1;
        step(100);
        // R12: write held continuously, collides with exchange shifts
        cur_req = "R12";
        shadow_wdata = 32'hDEAD_BEEF; shadow_wr = 1'b1;
        step(70);
        shadow_wr = 1'b0;
        // R3: start value delays the first shift
        cur_req = "R3";
        enable = 1'b0; step(2);
        cfg_preset = 12'd7; cfg_count_init = 12'd2; cfg_pos_preset = 5'd15; enable = 1'b1;
        step(60);
        cfg_count_init = 12'd0;
        // R6: loopback with a short preset that must be overridden
        cur_req = "R6";
        enable = 1'b0; step(2);
        shadow_wdata = 32'h8000_0001; shadow_wr = 1'b1; step(1); shadow_wr = 1'b0;
        cfg_preset = 12'd1; cfg_pos_preset = 5'd7; cfg_self_loop = 1'b1; enable = 1'b1;
        step(300);
        // R8: external pin clock
        cur_req = "R8";
        enable = 1'b0; step(2);
        cfg_self_loop = 1'b0; cfg_pos_preset = 5'd3; cfg_ext_clk = 1'b1; enable = 1'b1;
        for (int i = 0; i < 60; i++) begin
            ext_pin = ~ext_pin;
            step(3 + (i % 3));
        end
        // R9: inverted output clock
        cur_req = "R9";
        cfg_inv_clk = 1'b1;
        for (int i = 0; i < 20; i++) begin
            ext_pin = ~ext_pin;
            step(4);
        end
        cfg_ext_clk = 1'b0;
        step(20);
        // R10: output enable follows the configuration bit
        cur_req = "R10";
        for (int i = 0; i < 6; i++) begin
            cfg_oe = ~cfg_oe;
            step(2);
        end
        // R11: reset in the middle of a run
        cur_req = "R11";
        rst = 1'b1; step(2);
        rst = 1'b0; step(10);
        finish_run();
    end
endmodule